// File: doc/BRIEF.md
# Burst Soft-Start Duty Sequencer

This block sets the width of the gate-drive pulse at the start of each dimming burst so that the lamp current rises gradually and not in one step. A burst-start strobe launches a ramp of sixteen lamp cycles. Each lamp cycle is split into 32 sub-ticks, and `sub_tick` advances the count by one. For every lamp cycle the block presents a duty code, a pulse width in sub-ticks, and a gate-enable that is high for that many sub-ticks at the start of the cycle.

The ramp shape is set by a 32-bit profile word. It holds four 8-bit registers, with register 1 in bits 7:0, giving eight 4-bit slots. Each slot drives two consecutive lamp cycles. One slot code reuses the width that was in force when the previous burst ended. After the ramp the block raises `ramp_done` and passes through the steady-state width from the regulation loop until a burst-end strobe returns it to idle.

Top module: `soft_start_seq`

## Requirements
- R1: After reset `gate_en`, `ramp_done`, `duty_out` and `duty_code` are all 0, and the remembered last-burst width is 0.
- R2: A `burst_start` strobe begins a ramp of exactly 16 lamp cycles of 32 counted sub-ticks each. `ramp_done` is 0 throughout the ramp and becomes 1 as the 513th counted sub-tick begins.
- R3: During lamp cycle c (0..15) of the ramp, `duty_code` equals `profile_word[4*(c/2) +: 4]`. This is slot order register 1 low nibble, register 1 high nibble, then registers 2, 3 and 4 in the same low-then-high order.
- R4: During the ramp, codes 0 to 6 give a `duty_out` of that many sub-ticks (0% to 18.75% of a lamp cycle).
- R5: During the ramp, codes 8 to 15 give a `duty_out` of 0.
- R6: During the ramp, code 7 gives a `duty_out` equal to the width captured at the end of the previous active burst, or 0 if no burst has ended since reset.
- R7: While a burst is active, `gate_en` is 1 exactly when the sub-tick position within the current lamp cycle is below `duty_out`.
- R8: After the ramp, `duty_out` follows `steady_duty` in the same cycle, and `duty_code` is 0.
- R9: `burst_end` forces `gate_en` low in the same clock cycle. It captures the current `duty_out` as the last-burst width and returns all outputs to 0 on the next cycle. If both strobes arrive together, `burst_end` wins.
- R10: When `sub_tick` is 0 the sub-tick position does not advance, which stretches the lamp cycle.
- R11: A `burst_start` during an active burst restarts the ramp at lamp cycle 0, sub-tick 0.
- R12: A `burst_end` while idle changes neither the outputs nor the remembered last-burst width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_tick | input | 1 | Advances the sub-tick position by one |
| burst_start | input | 1 | One-cycle strobe that starts a ramp |
| burst_end | input | 1 | One-cycle strobe that ends the burst |
| profile_word | input | 32 | Four profile registers, register 1 in bits 7:0 |
| steady_duty | input | 5 | Steady-state width in sub-ticks from the regulation loop |
| duty_out | output | 5 | Width in sub-ticks for the current lamp cycle |
| duty_code | output | 4 | Profile code in use (0 when not ramping) |
| gate_en | output | 1 | Gate-drive enable pulse |
| ramp_done | output | 1 | High once the 16-cycle ramp has ended |

## Verification
The hardest case to reach is code 7 drawing a width that is not the reset value. For that, an earlier burst must end at a chosen width, and the ramp that follows must then hit a code-7 slot. The stimulus chains bursts for this. One burst ends during steady state at a known width. Another is cut off mid-ramp on a code-6 slot. An idle `burst_end` comes next and must leave the stored width alone. A final burst that uses code 7 in every slot then shows that width. One burst also runs with `sub_tick` toggling on alternate clocks, so the bench model has to count sub-ticks and not clocks.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;

    localparam int DEF_PHASE_W   = 5;
    localparam int DEF_CODE_W    = 4;
    localparam int DEF_NUM_REGS  = 4;
    localparam int DEF_REG_W     = 8;
    localparam int DEF_REPEAT_SH = 1;
    localparam int MAX_FIXED     = 6;
    localparam int REUSE_CODE    = 7;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_RAMP   = 2'd1,
        SEQ_STEADY = 2'd2
    } seq_state_e;

    function automatic logic is_active(input seq_state_e s);
        return s != SEQ_IDLE;
    endfunction

endpackage

// File: rtl/ss_cycle_timer.sv
module ss_cycle_timer
    import ss_seq_pkg::*;
#(
    parameter int PHASE_W     = DEF_PHASE_W,
    parameter int CYC_W       = 4,
    parameter int RAMP_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sub_tick,
    input  logic               burst_start,
    input  logic               burst_end,
    output seq_state_e         state,
    output logic [CYC_W-1:0]   cycle,
    output logic [PHASE_W-1:0] phase
);
    localparam logic [PHASE_W-1:0] PHASE_LAST = {PHASE_W{1'b1}};
    localparam logic [CYC_W-1:0]   CYC_LAST   = CYC_W'(RAMP_CYCLES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            cycle <= '0;
            phase <= '0;
        end else if (burst_end) begin
            state <= SEQ_IDLE;
            cycle <= '0;
            phase <= '0;
        end else if (burst_start) begin
            state <= SEQ_RAMP;
            cycle <= '0;
            phase <= '0;
        end else if (is_active(state) && sub_tick) begin
            if (phase == PHASE_LAST) begin
                phase <= '0;
                if (state == SEQ_RAMP) begin
                    if (cycle == CYC_LAST) begin
                        state <= SEQ_STEADY;
                        cycle <= '0;
                    end else begin
                        cycle <= cycle + 1'b1;
                    end
                end
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ss_profile_sel.sv
module ss_profile_sel #(
    parameter int NUM_REGS  = 4,
    parameter int REG_W     = 8,
    parameter int CODE_W    = 4,
    parameter int REPEAT_SH = 1,
    parameter int CYC_W     = 4
) (
    input  logic [NUM_REGS*REG_W-1:0] profile_word,
    input  logic [CYC_W-1:0]          cycle,
    output logic [CODE_W-1:0]         code
);
    localparam int SLOTS  = NUM_REGS * REG_W / CODE_W;
    localparam int SLOT_W = CYC_W - REPEAT_SH;

    logic [CODE_W-1:0] slot_code [SLOTS];
    logic [SLOT_W-1:0] slot_idx;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign slot_code[g] = profile_word[g*CODE_W +: CODE_W];
    end

    assign slot_idx = cycle[CYC_W-1:REPEAT_SH];
    assign code     = slot_code[slot_idx];
endmodule

// File: rtl/ss_duty_select.sv
module ss_duty_select
    import ss_seq_pkg::*;
#(
    parameter int CODE_W  = DEF_CODE_W,
    parameter int PHASE_W = DEF_PHASE_W
) (
    input  seq_state_e         state,
    input  logic [CODE_W-1:0]  code,
    input  logic [PHASE_W-1:0] steady_duty,
    input  logic [PHASE_W-1:0] last_duty,
    output logic [PHASE_W-1:0] duty_out,
    output logic [CODE_W-1:0]  duty_code
);
    logic [PHASE_W-1:0] ramp_width;

    always_comb begin
        if (code <= CODE_W'(MAX_FIXED))
            ramp_width = PHASE_W'(code);
        else if (code == CODE_W'(REUSE_CODE))
            ramp_width = last_duty;
        else
            ramp_width = '0;
    end

    always_comb begin
        unique case (state)
            SEQ_RAMP: begin
                duty_out  = ramp_width;
                duty_code = code;
            end
            SEQ_STEADY: begin
                duty_out  = steady_duty;
                duty_code = '0;
            end
            default: begin
                duty_out  = '0;
                duty_code = '0;
            end
        endcase
    end
endmodule

// File: rtl/ss_pulse_gen.sv
module ss_pulse_gen #(
    parameter int PHASE_W = 5
) (
    input  logic               active,
    input  logic               kill,
    input  logic [PHASE_W-1:0] phase,
    input  logic [PHASE_W-1:0] width,
    output logic               gate_en
);
    assign gate_en = active && !kill && (phase < width);
endmodule

// File: rtl/soft_start_seq.sv
module soft_start_seq
    import ss_seq_pkg::*;
#(
    parameter int PHASE_W   = DEF_PHASE_W,
    parameter int CODE_W    = DEF_CODE_W,
    parameter int NUM_REGS  = DEF_NUM_REGS,
    parameter int REG_W     = DEF_REG_W,
    parameter int REPEAT_SH = DEF_REPEAT_SH
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sub_tick,
    input  logic                      burst_start,
    input  logic                      burst_end,
    input  logic [NUM_REGS*REG_W-1:0] profile_word,
    input  logic [PHASE_W-1:0]        steady_duty,
    output logic [PHASE_W-1:0]        duty_out,
    output logic [CODE_W-1:0]         duty_code,
    output logic                      gate_en,
    output logic                      ramp_done
);
    localparam int SLOTS       = NUM_REGS * REG_W / CODE_W;
    localparam int RAMP_CYCLES = SLOTS << REPEAT_SH;
    localparam int CYC_W       = $clog2(RAMP_CYCLES);

    seq_state_e         state;
    logic [CYC_W-1:0]   cycle;
    logic [PHASE_W-1:0] phase;
    logic [CODE_W-1:0]  slot_code;
    logic [PHASE_W-1:0] last_duty;

    ss_cycle_timer #(
        .PHASE_W    (PHASE_W),
        .CYC_W      (CYC_W),
        .RAMP_CYCLES(RAMP_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .sub_tick   (sub_tick),
        .burst_start(burst_start),
        .burst_end  (burst_end),
        .state      (state),
        .cycle      (cycle),
        .phase      (phase)
    );

    ss_profile_sel #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W),
        .CODE_W   (CODE_W),
        .REPEAT_SH(REPEAT_SH),
        .CYC_W    (CYC_W)
    ) u_profile (
        .profile_word(profile_word),
        .cycle       (cycle),
        .code        (slot_code)
    );

    ss_duty_select #(
        .CODE_W (CODE_W),
        .PHASE_W(PHASE_W)
    ) u_select (
        .state      (state),
        .code       (slot_code),
        .steady_duty(steady_duty),
        .last_duty  (last_duty),
        .duty_out   (duty_out),
        .duty_code  (duty_code)
    );

    ss_pulse_gen #(
        .PHASE_W(PHASE_W)
    ) u_pulse (
        .active (is_active(state)),
        .kill   (burst_end),
        .phase  (phase),
        .width  (duty_out),
        .gate_en(gate_en)
    );

    // width held for reuse by the next burst's code-7 slots
    always_ff @(posedge clk) begin
        if (rst)
            last_duty <= '0;
        else if (burst_end && is_active(state))
            last_duty <= duty_out;
    end

    assign ramp_done = (state == SEQ_STEADY);
endmodule

// File: rtl/ss_seq_checker.sv
module ss_seq_checker #(
    parameter int PHASE_W = 5,
    parameter int CODE_W  = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               burst_start,
    input logic               burst_end,
    input logic [PHASE_W-1:0] steady_duty,
    input logic [PHASE_W-1:0] duty_out,
    input logic [CODE_W-1:0]  duty_code,
    input logic               gate_en,
    input logic               ramp_done
);
    assert_done_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (ramp_done && !burst_end && !burst_start) |=> ramp_done);

    assert_fixed_code_R4: assert property (@(posedge clk) disable iff (rst)
        (!ramp_done && duty_code <= CODE_W'(6)) |-> (duty_out == PHASE_W'(duty_code)));

    assert_high_code_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (duty_code >= CODE_W'(8)) |-> (duty_out == '0));

    assert_gate_needs_width_R7: assert property (@(posedge clk) disable iff (rst)
        gate_en |-> (duty_out != '0));

    assert_steady_follow_R8: assert property (@(posedge clk) disable iff (rst)
        ramp_done |-> (duty_out == steady_duty && duty_code == '0));

    assert_end_idle_R9: assert property (@(posedge clk) disable iff (rst)
        burst_end |=> (!ramp_done && !gate_en && duty_out == '0));

    assert_start_ramp_R11: assert property (@(posedge clk) disable iff (rst)
        (burst_start && !burst_end) |=> !ramp_done);
endmodule

bind soft_start_seq ss_seq_checker #(
    .PHASE_W(PHASE_W),
    .CODE_W (CODE_W)
) u_seq_chk (
    .clk        (clk),
    .rst        (rst),
    .burst_start(burst_start),
    .burst_end  (burst_end),
    .steady_duty(steady_duty),
    .duty_out   (duty_out),
    .duty_code  (duty_code),
    .gate_en    (gate_en),
    .ramp_done  (ramp_done)
);

// File: tb/soft_start_seq_test.sv
`timescale 1ns/1ps
module soft_start_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sub_tick = 1'b1;
    logic        burst_start = 1'b0;
    logic        burst_end = 1'b0;
    logic [31:0] profile_word = '0;
    logic [4:0]  steady_duty = '0;
    logic [4:0]  duty_out;
    logic [3:0]  duty_code;
    logic        gate_en;
    logic        ramp_done;

    int n_cmp = 0;
    int n_bad = 0;
    int model_last = 0;

    always #10 clk = ~clk;

    soft_start_seq uut (
        .clk(clk), .rst(rst), .sub_tick(sub_tick),
        .burst_start(burst_start), .burst_end(burst_end),
        .profile_word(profile_word), .steady_duty(steady_duty),
        .duty_out(duty_out), .duty_code(duty_code),
        .gate_en(gate_en), .ramp_done(ramp_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input logic [31:0] prof, input int t);
        if (t >= 512) return 0;
        return int'(prof[4*(t/64) +: 4]);
    endfunction

    function automatic int exp_width(input logic [31:0] prof, input int st, input int t);
        int c;
        if (t >= 512) return st;
        c = exp_code(prof, t);
        if (c <= 6) return c;
        if (c == 7) return model_last;
        return 0;
    endfunction

    function automatic string width_req(input logic [31:0] prof, input int t);
        int c;
        if (t >= 512) return "R8";
        c = exp_code(prof, t);
        if (c <= 6) return "R4";
        if (c == 7) return "R6";
        return "R5";
    endfunction

    task automatic check_at(input string tag, input logic [31:0] prof, input int st, input int t);
        int w;
        w = exp_width(prof, st, t);
        chk({tag, " R7 gate"}, int'(gate_en), ((t % 32) < w) ? 1 : 0);
        chk({tag, " R2 done"}, int'(ramp_done), (t >= 512) ? 1 : 0);
        chk({tag, " R3 code"}, int'(duty_code), exp_code(prof, t));
        chk({tag, " ", width_req(prof, t), " width"}, int'(duty_out), w);
    endtask

    // t counts sub-ticks seen since the start strobe
    task automatic run_burst(input logic [31:0] prof, input int st, input int nclk,
                             input bit do_end, input bit stall, input string tag);
        int t;
        profile_word = prof;
        steady_duty  = 5'(st);
        @(negedge clk);
        burst_start = 1'b1;
        sub_tick    = 1'b1;
        @(negedge clk);
        burst_start = 1'b0;
        t = 0;
        for (int i = 0; i < nclk; i++) begin
            #1;
            check_at(tag, prof, st, t);
            sub_tick = stall ? ((i % 2) == 0) : 1'b1;
            if (sub_tick) t++;
            @(negedge clk);
        end
        if (do_end) begin
            #1;
            check_at(tag, prof, st, t);
            burst_end = 1'b1;
            #1;
            chk({tag, " R9 gate killed"}, int'(gate_en), 0);
            model_last = exp_width(prof, st, t);
            @(negedge clk);
            burst_end = 1'b0;
            sub_tick  = 1'b1;
            #1;
            chk({tag, " R9 idle gate"}, int'(gate_en), 0);
            chk({tag, " R9 idle done"}, int'(ramp_done), 0);
            chk({tag, " R9 idle width"}, int'(duty_out), 0);
            chk({tag, " R9 idle code"}, int'(duty_code), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 gate", int'(gate_en), 0);
        chk("R1 done", int'(ramp_done), 0);
        chk("R1 width", int'(duty_out), 0);
        chk("R1 code", int'(duty_code), 0);

        // all codes 0..7 once, code 7 meets the reset value of the stored width
        run_burst(32'h7654_3210, 10, 600, 1'b1, 1'b0, "R1 base");
        // codes 7, 8..15 and fixed codes, sub_tick on alternate clocks
        run_burst(32'h7F8E_6A79, 3, 1100, 1'b1, 1'b1, "R10 stall");
        // burst cut short by a restart, then the restart aborted mid-ramp on code 6
        run_burst(32'h1234_5677, 20, 200, 1'b0, 1'b0, "R6 pre");
        run_burst(32'h6666_6666, 31, 100, 1'b1, 1'b0, "R11 restart");
        // burst_end while idle must leave everything alone
        @(negedge clk);
        burst_end = 1'b1;
        #1;
        chk("R12 idle gate", int'(gate_en), 0);
        chk("R12 idle done", int'(ramp_done), 0);
        @(negedge clk);
        burst_end = 1'b0;
        #1;
        chk("R12 width", int'(duty_out), 0);
        // every slot code 7 shows the width kept from the aborted burst
        run_burst(32'h7777_7777, 0, 530, 1'b1, 1'b0, "R12 reuse");
        chk("R6 kept width", model_last, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule